// File: doc/BRIEF.md
# Three-Level Extended Physical Address Page Walker

This block turns a 32-bit virtual address into a physical address that can be wider than 32 bits. It reads a three-level hierarchy of translation tables from memory. A root pointer names a small top table of four entries. A top entry points to a directory of 512 entries, a directory entry points to a page table of 512 entries, and a page-table entry names a 4 KiB page frame. Every entry is 8 bytes wide, so the frame field can describe physical addresses of up to 52 bits. Virtual addresses themselves stay 32 bits wide.

A client presents a request with a valid/ready handshake, together with the root pointer and a paging-enable flag. The walker issues one 64-bit read at a time on a memory port, using a request/ready handshake for the address and a valid strobe for the returned data. When the walk ends, a one-cycle result pulse carries either the physical address or a page fault, together with the level at which the fault occurred. Only one walk is handled at a time.

Top module: `pae_walker`

## Requirements
- R1: The first read goes to root_base with its low 5 bits replaced by zero, plus 8 times vaddr[31:30]. Every read address is a multiple of 8.
- R2: The directory read goes to the frame base of the top entry plus 8 times vaddr[29:21]. The page-table read goes to the frame base of the directory entry plus 8 times vaddr[20:12]. A frame base is entry bits [PA_W-1:12] followed by twelve zero bits.
- R3: A successful walk returns {page-table entry bits [PA_W-1:12], vaddr[11:0]}, with done_fault 0 and done_level 0. Entry bits [63:PA_W] and [11:1] have no effect on the result.
- R4: Bit 0 of an entry is the present flag. When a fetched entry has bit 0 clear, the walk ends at once with done_fault 1, done_paddr 0, and done_level set to 0 for the top table, 1 for the directory or 2 for the page table. No further read is issued.
- R5: When paging_en is 0 at acceptance, the result arrives in the next cycle. It equals the zero-extended vaddr with done_fault 0, and no memory read is issued.
- R6: req_ready is high only while no walk is in progress. A request presented while the walker is busy is ignored, and its inputs have no effect on any result.
- R7: Once mem_req_valid is raised, it stays high with an unchanged address until mem_req_ready is seen. A mem_rsp_valid that arrives while no read is outstanding is ignored.
- R8: done_valid is high for exactly one cycle per accepted request, and req_ready is high in that cycle. A new request can therefore be accepted in the same cycle as a result is delivered.
- R9: After reset, req_ready is 1, and mem_req_valid and done_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Top-table base pointer (bits [4:0] ignored) |
| paging_en | input | 1 | 1 = translate, 0 = pass address through |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | PA_W | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (one table entry) |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_level | output | 2 | Faulting level (0 top, 1 directory, 2 page table) |
| done_paddr | output | PA_W | Translated physical address |

## Verification
Two events can fall in the same cycle: the result pulse of one walk and the acceptance of the next request, because the walker is idle while it presents a result. The bench provokes this by keeping req_valid high continuously across back-to-back stretches of requests. In one stretch it mixes requests with paging enabled and disabled, so that a pass-through result can follow a faulting or completed walk in the very next cycle. Each result is compared with a value the bench computes from its own arithmetic memory image and with the number of reads that walk issued. Garbage request inputs are applied while the walker is busy, and stray response strobes are applied while no read is outstanding; both must leave every result unchanged.

// File: rtl/pae_walker.sv
module pae_walker #(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic [31:0]     root_base,
  input  logic            paging_en,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_fault,
  output logic [1:0]      done_level,
  output logic [PA_W-1:0] done_paddr
);
  localparam int FR_W = PA_W - 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t             st;
  logic [1:0]      lvl;
  logic [31:0]     va_q;
  logic [26:0]     root_q;
  logic [FR_W-1:0] base_q;
  logic [8:0]      idx;
  logic            accept;

  initial begin
    AST_PA_RANGE: assert (PA_W >= 32 && PA_W <= 52); // R3
  end

  assign req_ready     = (st == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (st == S_REQ);
  assign idx           = (lvl == 2'd1) ? va_q[29:21] : va_q[20:12];
  assign mem_req_addr  = (lvl == 2'd0) ? PA_W'({root_q, va_q[31:30], 3'b000})
                                       : {base_q, idx, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lvl        <= 2'd0;
      va_q       <= '0;
      root_q     <= '0;
      base_q     <= '0;
      done_valid <= 1'b0;
      done_fault <= 1'b0;
      done_level <= 2'd0;
      done_paddr <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          va_q   <= req_vaddr;
          root_q <= root_base[31:5];
          lvl    <= 2'd0;
          if (paging_en) begin
            st <= S_REQ;
          end else begin
            done_valid <= 1'b1;
            done_fault <= 1'b0;
            done_level <= 2'd0;
            done_paddr <= PA_W'(req_vaddr);
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_fault <= 1'b1;
            done_level <= lvl;
            done_paddr <= '0;
          end else if (lvl == 2'd2) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_fault <= 1'b0;
            done_level <= 2'd0;
            done_paddr <= {mem_rsp_data[PA_W-1:12], va_q[11:0]};
          end else begin
            base_q <= mem_rsp_data[PA_W-1:12];
            lvl    <= lvl + 2'd1;
            st     <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_ready); // R8
  AST_FAULT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_level != 2'd3 && done_paddr == '0); // R4
  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !req_valid |=> !mem_req_valid); // R4
endmodule

// File: tb/pae_walker_tb.sv
module pae_walker_tb_top;
  localparam int PA_W = 36;
  localparam int NSTIM = 448;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_vaddr = '0;
  logic [31:0]     root_base = '0;
  logic            paging_en = 1'b0;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            done_valid;
  logic            done_fault;
  logic [1:0]      done_level;
  logic [PA_W-1:0] done_paddr;

  always #2 clk = ~clk;

  pae_walker #(.PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .root_base(root_base), .paging_en(paging_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
    .done_fault(done_fault), .done_level(done_level), .done_paddr(done_paddr)
  );

  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [63:0] entry(input logic [PA_W-1:0] a);
    logic [63:0] e;
    e[63:PA_W] = '1;
    e[PA_W-1:12] = (PA_W-12)'((a >> 3) * 13 + 7);
    e[11:1] = 11'h5A5;
    e[0] = ((a >> 3) % 13) != 0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic            e_pend = 0;
  logic            e_fault;
  logic [1:0]      e_lvl;
  logic [PA_W-1:0] e_pa;
  int              e_reads;
  int              walk_reads = 0;

  task automatic predict(input logic [31:0] r, input logic [31:0] va, input bit pg);
    logic [PA_W-1:0] a;
    logic [63:0] e;
    e_fault = 0; e_lvl = 0; e_reads = 0;
    if (!pg) begin e_pa = PA_W'(va); return; end
    a = PA_W'(r & 32'hFFFF_FFE0) + PA_W'(va[31:30]) * 8;
    e = entry(a); e_reads = 1;
    if (!e[0]) begin e_fault = 1; e_pa = 0; return; end
    a = {e[PA_W-1:12], 12'h000} + PA_W'(va[29:21]) * 8;
    e = entry(a); e_reads = 2;
    if (!e[0]) begin e_fault = 1; e_lvl = 1; e_pa = 0; return; end
    a = {e[PA_W-1:12], 12'h000} + PA_W'(va[20:12]) * 8;
    e = entry(a); e_reads = 3;
    if (!e[0]) begin e_fault = 1; e_lvl = 2; e_pa = 0; return; end
    e_pa = {e[PA_W-1:12], va[11:0]};
  endtask

  initial begin
    int cyc = 0;
    int si = 0;
    int n_done = 0;
    int n_faults = 0;
    int n_b2b = 0;
    bit pend = 0;
    int cnt = 0;
    logic [PA_W-1:0] paddr = '0;
    bit held = 0;
    logic [PA_W-1:0] held_addr = '0;
    bit gap = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R9 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(done_valid == 1'b0, "R9 done_valid", 64'(done_valid), 64'd0);
    rst_n = 1'b1;
    while (n_done < NSTIM) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", 64'(n_done), 64'(NSTIM));
        break;
      end
      // result monitor
      if (done_valid) begin
        n_done++;
        chk(e_pend == 1'b1, "R8 result without request", 64'(done_valid), 64'd0);
        chk(req_ready == 1'b1, "R8 ready with result", 64'(req_ready), 64'd1);
        chk(done_fault == e_fault, "R4 fault flag", 64'(done_fault), 64'(e_fault));
        if (e_fault) begin
          n_faults++;
          chk(done_level == e_lvl, "R4 fault level", 64'(done_level), 64'(e_lvl));
        end
        chk(done_paddr == e_pa, "R3 physical address", 64'(done_paddr), 64'(e_pa));
        chk(walk_reads == e_reads, "R5 read count (R4 stop / R2 levels)", 64'(walk_reads), 64'(e_reads));
        e_pend = 0;
      end
      // memory model
      if (held) begin
        chk(mem_req_valid && mem_req_addr == held_addr, "R7 request hold",
            64'(mem_req_addr), 64'(held_addr));
      end
      mem_rsp_valid = 1'b0;
      mem_rsp_data = 64'h0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = entry(paddr);
          pend = 0;
        end else cnt--;
      end else if (cyc % 5 == 2) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = 64'hFFFF_FFFF_FFFF_FFFE;
      end
      mem_req_ready = (cyc % 4) != 1;
      held = 0;
      if (mem_req_valid) begin
        chk(mem_req_addr[2:0] == 3'b000, "R1 read alignment", 64'(mem_req_addr), 64'd0);
        if (mem_req_ready) begin
          pend = 1;
          paddr = mem_req_addr;
          cnt = int'(mem_req_addr[4:3]);
          walk_reads++;
        end else begin
          held = 1;
          held_addr = mem_req_addr;
        end
      end
      // driver
      if (req_ready && si < NSTIM && !(si < 256 && gap)) begin
        logic [31:0] va;
        logic [31:0] rb;
        bit pg;
        va = {si[1:0], 9'(si * 37 + 5), 9'(si * 91 + 3), 12'(si * 123 + 7)};
        rb = {27'(si * 977 + 100), 5'(si)};
        pg = (si < 384) ? 1'b1 : ((si % 3) != 0);
        if (done_valid) n_b2b++;
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = rb;
        paging_en = pg;
        predict(rb, va, pg);
        e_pend = 1;
        walk_reads = 0;
        si++;
        gap = 1;
      end else if (!req_ready) begin
        req_valid = 1'b1;
        req_vaddr = ~req_vaddr;
        root_base = ~root_base;
        paging_en = ~paging_en;
      end else begin
        req_valid = 1'b0;
        gap = 0;
      end
    end
    chk(n_faults > 0, "R4 faults seen", 64'(n_faults), 64'd1);
    chk(n_b2b > 0, "R8 accept with result", 64'(n_b2b), 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule